// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Transmitter

This block drives one output pin with asynchronous serial frames. Each bit period is set by a phase accumulator rather than an integer divider. On every clock the accumulator adds a programmable 16-bit step. Each carry out of the accumulator ends the current bit. Because of this, bit lengths alternate between two neighbouring cycle counts, and a fractional ratio of system clock to baud rate holds on average. For example, with a 16-bit step of 9830, a frame of ten bits lasts 67 clocks.

Software pushes data words through a single-entry holding register, and the block adds a low start bit and a high stop bit around each one. Data goes out least-significant bit first. The word length is set through a minus-one field, so a value of 7 gives the usual 8 data bits. When the holding register already has a word in it at the end of a frame, the next start bit follows the stop bit directly, with no idle time between them. Software polls a full flag before each write. A write made while the flag is high is discarded, and a one-cycle pulse reports that it was discarded.

Top module: `nco_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1, `full` is 0 and `wr_drop` is 0.
- R2: A write (`wr_en`=1 with `full`=0) while no frame is running puts the start bit (`tx`=0) on the line from the next clock edge onward.
- R3: A frame is one start bit at 0, then `len_m1`+1 data bits (1 to 32) starting with `wr_data[0]`, then one stop bit at 1. `len_m1` is sampled when the frame starts.
- R4: The accumulator is cleared when a frame starts. Counting t edges from the frame's first edge (the edge with t=0), the line carries bit number floor(t*`step`/65536) of the frame: 0 is the start bit, 1 to n are the data bits, n+1 is the stop bit. A bit boundary therefore falls at every carry out of the 16-bit sum.
- R5: When a word is held at the moment the stop bit ends, that word's start bit begins on that same edge, with no idle cycle.
- R6: A write accepted while a frame is running is stored, and `full` becomes 1 at the next edge. `full` returns to 0 on the edge where the held word starts its frame.
- R7: A write made while `full` is 1 is ignored and never transmitted. `wr_drop` is 1 for exactly the one cycle that follows that write.
- R8: Bit periods down to 3 clocks work. With a step of 21846, every frame boundary still follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 16 | Phase increment added each clock |
| len_m1 | input | 5 | Data bits per frame minus one |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Word to send, bit 0 first |
| tx | output | 1 | Serial line, idles high |
| full | output | 1 | Holding register occupied |
| wr_drop | output | 1 | Pulse: previous write was discarded |

## Verification
The hardest case to reach is the exact edge where a stop bit ends while a word is held. On that edge three things must happen in the same cycle: the holding register drains, the accumulator clears and the new start bit begins. A write that arrives one cycle too late would be lost or would show up as a gap. The stimulus reaches this edge by writing the second word on the clock right after the first one and a third word on the clock after that. The bench then compares every cycle of both frames with the floor(t*step/65536) bit-index formula, and checks that `full` clears exactly at the boundary between the frames. It then watches the line after the second frame to confirm that the third word never appears.

// File: rtl/nco_uart_tx.sv
module nco_uart_tx #(
  parameter int ACC_W    = 16,
  parameter int MAX_BITS = 32,
  localparam int LEN_W   = $clog2(MAX_BITS),
  localparam int CNT_W   = $clog2(MAX_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ACC_W-1:0]    step,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  output logic                tx,
  output logic                full,
  output logic                wr_drop
);

  logic                busy;
  logic [ACC_W-1:0]    acc;
  logic [CNT_W-1:0]    bitcnt;
  logic [LEN_W-1:0]    len_q;
  logic [MAX_BITS-1:0] sh, hold;

  logic             carry;
  logic [ACC_W-1:0] acc_nx;
  logic [CNT_W-1:0] stop_idx;
  logic             frame_end, take_new, start;

  assign {carry, acc_nx} = {1'b0, acc} + {1'b0, step};
  assign stop_idx  = CNT_W'(len_q) + CNT_W'(2);
  assign frame_end = busy && carry && (bitcnt == stop_idx);
  assign take_new  = wr_en && !full && (!busy || frame_end);
  assign start     = take_new || (frame_end && full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      acc    <= '0;
      bitcnt <= '0;
      len_q  <= '0;
      sh     <= '0;
      tx     <= 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      acc    <= '0;
      bitcnt <= '0;
      len_q  <= len_m1;
      sh     <= full ? hold : wr_data;
      tx     <= 1'b0;
    end else if (frame_end) begin
      busy <= 1'b0;
      acc  <= acc_nx;
      tx   <= 1'b1;
    end else if (busy) begin
      acc <= acc_nx;
      if (carry) begin
        bitcnt <= bitcnt + CNT_W'(1);
        if (bitcnt == stop_idx - CNT_W'(1)) begin
          tx <= 1'b1;
        end else begin
          tx <= sh[0];
          sh <= sh >> 1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      hold    <= '0;
      wr_drop <= 1'b0;
    end else begin
      wr_drop <= wr_en && full;
      if (frame_end && full)
        full <= 1'b0;
      else if (wr_en && !full && busy && !frame_end) begin
        full <= 1'b1;
        hold <= wr_data;
      end
    end
  end

endmodule

module nco_uart_tx_chk #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tx,
  input logic             full,
  input logic             wr_drop,
  input logic             busy,
  input logic             frame_end,
  input logic [CNT_W-1:0] bitcnt,
  input logic [LEN_W-1:0] len_q
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx && !full)); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !busy) |=> (!tx && busy)); // R2

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bitcnt == CNT_W'(len_q) + CNT_W'(2)) |-> tx); // R3

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && full) |=> (busy && !tx && !full)); // R5

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && busy && !frame_end) |=> full); // R6

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> $past(wr_en && full)); // R7

  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !frame_end) |=> full); // R7

endmodule

bind nco_uart_tx nco_uart_tx_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx(tx), .full(full),
  .wr_drop(wr_drop), .busy(busy), .frame_end(frame_end),
  .bitcnt(bitcnt), .len_q(len_q)
);

// File: tb/tb_nco_uart_tx.sv
module tb_nco_uart_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] step = 16'd0;
  logic [4:0]  len_m1 = 5'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tx, full, wr_drop;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  nco_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .step(step), .len_m1(len_m1),
    .wr_en(wr_en), .wr_data(wr_data), .tx(tx), .full(full), .wr_drop(wr_drop)
  );

  localparam int NV = 6;
  localparam int          V_STEP [NV] = '{9830, 21846, 40000, 5000, 16384, 21846};
  localparam int          V_NB   [NV] = '{8, 8, 1, 32, 16, 8};
  localparam logic [31:0] V_DATA [NV] = '{32'hA5, 32'h3C, 32'h1, 32'hDEADBEEF,
                                          32'h8001, 32'hC4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input int s, input int nb);
    return int'(((longint'(nb) + 2) * 65536 + s - 1) / s);
  endfunction

  function automatic logic exp_bit(input int t, input int s, input int nb, input logic [31:0] d);
    longint idx;
    idx = (longint'(t) * s) >> 16;
    if (idx == 0) return 1'b0;
    if (idx <= nb) return d[int'(idx) - 1];
    return 1'b1;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 reset tx", int'(tx), 1);
    check(full === 1'b0, "R1 reset full", int'(full), 0);
    check(wr_drop === 1'b0, "R1 reset wr_drop", int'(wr_drop), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R8
    for (int v = 0; v < NV; v++) begin
      int tl, bad;
      tl = frame_len(V_STEP[v], V_NB[v]);
      step    = 16'(V_STEP[v]);
      len_m1  = 5'(V_NB[v] - 1);
      wr_data = V_DATA[v];
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check(tx === 1'b0, "R2 start bit next edge", int'(tx), 0);
      bad = 0;
      for (int t = 0; t < tl; t++) begin
        if (tx !== exp_bit(t, V_STEP[v], V_NB[v], V_DATA[v])) bad++;
        @(negedge clk);
      end
      check(bad == 0, (V_STEP[v] == 21846) ? "R8 three-clock bits" : "R3 R4 frame bits and timing", bad, 0);
      check(tx === 1'b1 && full === 1'b0, "R1 idle after frame", int'(tx), 1);
      repeat (3) @(negedge clk);
    end

    // back-to-back with a dropped third write: R5 R6 R7
    begin
      int tl, bad_ab, bad_tail;
      step = 16'd16384;
      len_m1 = 5'd7;
      tl = frame_len(16384, 8);
      wr_data = 32'h5A;
      wr_en = 1'b1;
      bad_ab = 0;
      bad_tail = 0;
      @(negedge clk);
      for (int t = 0; t < 3 * tl; t++) begin
        logic e;
        if (t < tl) e = exp_bit(t, 16384, 8, 32'h5A);
        else if (t < 2 * tl) e = exp_bit(t - tl, 16384, 8, 32'h96);
        else e = 1'b1;
        if (tx !== e) begin
          if (t < 2 * tl) bad_ab++; else bad_tail++;
        end
        if (t == 0) wr_data = 32'h96;
        if (t == 1) begin
          check(full === 1'b1, "R6 full after write while busy", int'(full), 1);
          wr_data = 32'h0F;
        end
        if (t == 2) begin
          check(wr_drop === 1'b1, "R7 drop pulse", int'(wr_drop), 1);
          check(full === 1'b1, "R7 full kept", int'(full), 1);
          wr_en = 1'b0;
        end
        if (t == 3) check(wr_drop === 1'b0, "R7 drop one cycle", int'(wr_drop), 0);
        if (t == tl - 1) check(full === 1'b1, "R6 full until boundary", int'(full), 1);
        if (t == tl) begin
          check(full === 1'b0, "R6 full clears at frame start", int'(full), 0);
          check(tx === 1'b0, "R5 start follows stop", int'(tx), 0);
        end
        @(negedge clk);
      end
      check(bad_ab == 0, "R5 back-to-back frames", bad_ab, 0);
      check(bad_tail == 0, "R7 dropped word not sent", bad_tail, 0);
    end

    // reset in mid-frame: R1
    wr_data = 32'hFF;
    wr_en = 1'b1;
    @(negedge clk);
    wr_data = 32'h11;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(tx === 1'b1 && full === 1'b0, "R1 reset mid-frame", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule